// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Target

This block is the digital core of a small serial EEPROM slave that a host drives over three wires: a chip select, a serial clock and a data-in line, with one data-out line going back. The host frames each transaction with chip select. Inside the frame it sends a start bit, a two-bit opcode and an address. Then it either shifts write data in or clocks read data out. A static organisation input chooses byte-wide storage (2^ADDR_W bytes) or word-wide storage (2^(ADDR_W-1) sixteen-bit words). The same input also sets how many address bits the frame carries.

Writes and the erase-all command are gated by an enable latch, which is clear at reset. Programming is self-timed: it begins when chip select is released after a complete frame and lasts PROG_CYCLES system clocks. During that time data-out, polled with chip select high, reads 0. It reads 1 once the array is ready. The serial clock is oversampled by the system clock `clk`. Every action of the block happens on a detected rising edge of the serial clock.

Top module: `tw_eeprom`

## Requirements
- R1: A frame starts at the first serial-clock rise that samples sdi_i = 1 with sel_i high and the block idle. Zeros before it are ignored. The next 2 bits are the opcode and the next AW bits are the address, all MSB first. AW = ADDR_W when wide_i = 0 (byte organisation) and ADDR_W-1 when wide_i = 1 (word organisation). wide_i is sampled with the start bit.
- R2: Opcode 2'b00 reads. After the rise that samples the last address bit, sdo_o shows a 0 dummy bit. Each later rise presents the next data bit, MSB first: 8 bits per byte, 16 per word.
- R3: While sel_i stays high, a read continues with the next address without a gap, and wraps from the last address to 0.
- R4: Opcode 2'b10 writes. It takes 8 (byte) or 16 (word) data bits, MSB first, after the address. The programming cycle starts when sel_i falls after all data bits have arrived, and the new value becomes readable after that cycle.
- R5: Opcode 2'b01 is a control frame, decoded from the two most significant address bits. 2'b11 sets the enable latch and 2'b00 clears it. The latch is clear after reset.
- R6: A control frame with address top bits 2'b10 (erase-all) sets every byte of the array to 8'hFF through one programming cycle.
- R7: When the enable latch is clear, write and erase-all frames are ignored. No programming cycle starts and the array keeps its contents.
- R8: With sel_i high, sdo_o is 0 while a programming cycle runs and 1 when idle and not reading. The cycle lasts exactly PROG_CYCLES clocks: sdo_o first reads 1 on the (PROG_CYCLES+1)-th falling clock edge after the edge at which sel_i was driven low.
- R9: A start bit that arrives during a programming cycle is ignored together with the rest of its frame.
- R10: In word organisation, word k occupies byte 2k (bits 15:8) and byte 2k+1 (bits 7:0) of the byte-organised view.
- R11: sdo_o is 0 whenever sel_i is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_i | input | 1 | Chip select, active high; frames each transaction |
| sclk_i | input | 1 | Serial clock; the block acts on its rising edges |
| sdi_i | input | 1 | Serial data in (start bit, opcode, address, write data) |
| wide_i | input | 1 | Organisation: 0 = bytes, 1 = 16-bit words |
| sdo_o | output | 1 | Serial data out: read bits, or ready/busy status |

## Verification
A wrong bit counter or address register shows up first in a read. The dummy bit, a misaligned word, or a missing wrap from the last address to 0 appears within one word time of the fault, and the bench reads the whole array in both organisations. A wrongly set enable latch or pending-operation state shows up at the next chip-select release. In that case sdo_o either goes low when it should stay high, or stays high when it should go low. The exact busy length is counted on every programmed write. The byte placement of word writes is observed by reading the same array back in byte organisation.

// File: rtl/tw_eeprom_pkg.sv
package tw_eeprom_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_DATA,
        ST_READ,
        ST_HOLD
    } tw_state_e;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_CTRL  = 2'b01,
        OP_WRITE = 2'b10,
        OP_RSVD  = 2'b11
    } tw_op_e;

    typedef enum logic [1:0] {
        PG_NONE,
        PG_WRITE,
        PG_ERASE
    } tw_pgm_e;

    // Control sub-codes carried in the two top address bits
    localparam logic [1:0] CTL_DISABLE = 2'b00;
    localparam logic [1:0] CTL_ERASE   = 2'b10;
    localparam logic [1:0] CTL_ENABLE  = 2'b11;

endpackage

// File: rtl/tw_eeprom_store.sv
module tw_eeprom_store #(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase_i,
    input  logic              wr_en_i,
    input  logic              wr_wide_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [15:0]       wr_data_i,
    input  logic              rd_wide_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [15:0]       rd_word_o
);

    localparam int BYTES = 1 << ADDR_W;

    logic [7:0] mem_q [BYTES];

    // Array contents are non-volatile: no reset on the cells
    always_ff @(posedge clk) begin
        if (erase_i) begin
            for (int i = 0; i < BYTES; i++) begin
                mem_q[i] <= 8'hFF;
            end
        end else if (wr_en_i) begin
            if (wr_wide_i) begin
                mem_q[{wr_addr_i[ADDR_W-2:0], 1'b0}] <= wr_data_i[15:8];
                mem_q[{wr_addr_i[ADDR_W-2:0], 1'b1}] <= wr_data_i[7:0];
            end else begin
                mem_q[wr_addr_i] <= wr_data_i[7:0];
            end
        end
    end

    logic [7:0] hi_byte, lo_byte;
    assign hi_byte   = mem_q[{rd_addr_i[ADDR_W-2:0], 1'b0}];
    assign lo_byte   = mem_q[{rd_addr_i[ADDR_W-2:0], 1'b1}];
    assign rd_word_o = rd_wide_i ? {hi_byte, lo_byte} : {8'h00, mem_q[rd_addr_i]};

    // R6: erase-all leaves both ends of the array at all ones
    a_r6_erase_fills: assert property (@(posedge clk) disable iff (!rst_n)
        erase_i |=> (mem_q[0] == 8'hFF && mem_q[BYTES-1] == 8'hFF));

    // R10: a word write puts its upper half in the even byte
    a_r10_word_hi_even: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_wide_i && !erase_i) |=>
        mem_q[{$past(wr_addr_i[ADDR_W-2:0]), 1'b0}] == $past(wr_data_i[15:8]));

endmodule

// File: rtl/tw_eeprom_timer.sv
module tw_eeprom_timer #(
    parameter int PROG_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);

    localparam int CW = $clog2(PROG_CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i) begin
            cnt_d = CW'(PROG_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);
    assign done_o = (cnt_q == CW'(1));

    // R9: a new cycle is never launched on top of a running one
    a_r9_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o);

    // R8: the last counted cycle is followed by ready
    a_r8_done_then_ready: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

endmodule

// File: rtl/tw_eeprom.sv
module tw_eeprom
    import tw_eeprom_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int PROG_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_i,
    input  logic sclk_i,
    input  logic sdi_i,
    input  logic wide_i,
    output logic sdo_o
);

    localparam int SREG_W = 2 + ADDR_W;
    localparam int CNT_W  = $clog2(SREG_W + 16);

    typedef struct packed {
        tw_state_e         st;
        logic              sk;
        logic              wide;
        logic [CNT_W-1:0]  cnt;
        logic [SREG_W-1:0] sreg;
        logic [15:0]       wdata;
        logic [ADDR_W-1:0] addr;
        logic              ewen;
        logic              dout;
        tw_pgm_e           pend;
        tw_pgm_e           act;
        logic [ADDR_W-1:0] p_addr;
        logic [15:0]       p_data;
        logic              p_wide;
    } regs_t;

    regs_t d, q;

    logic        start, busy, done;
    logic [15:0] rd_word;
    logic        sk_rise;

    // Frame decode scratch values
    logic [SREG_W-1:0] nsreg;
    logic [15:0]       nwdata;
    logic [CNT_W-1:0]  aw, dw;
    tw_op_e            op;
    logic [ADDR_W-1:0] f_addr;
    logic [1:0]        f_top;
    logic [3:0]        bidx;

    tw_eeprom_timer #(.PROG_CYCLES(PROG_CYCLES)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .busy_o  (busy),
        .done_o  (done)
    );

    tw_eeprom_store #(.ADDR_W(ADDR_W)) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .erase_i   (done && q.act == PG_ERASE),
        .wr_en_i   (done && q.act == PG_WRITE),
        .wr_wide_i (q.p_wide),
        .wr_addr_i (q.p_addr),
        .wr_data_i (q.p_data),
        .rd_wide_i (q.wide),
        .rd_addr_i (q.addr),
        .rd_word_o (rd_word)
    );

    assign sk_rise = sclk_i & ~q.sk;

    always_comb begin
        d      = q;
        start  = 1'b0;
        d.sk   = sclk_i;
        aw     = q.wide ? CNT_W'(ADDR_W - 1) : CNT_W'(ADDR_W);
        dw     = q.wide ? CNT_W'(16) : CNT_W'(8);
        nsreg  = {q.sreg[SREG_W-2:0], sdi_i};
        nwdata = {q.wdata[14:0], sdi_i};
        bidx   = 4'(dw - 1'b1) - q.cnt[3:0];
        if (q.wide) begin
            op     = tw_op_e'(nsreg[SREG_W-2:SREG_W-3]);
            f_addr = {1'b0, nsreg[ADDR_W-2:0]};
            f_top  = nsreg[ADDR_W-2:ADDR_W-3];
        end else begin
            op     = tw_op_e'(nsreg[SREG_W-1:SREG_W-2]);
            f_addr = nsreg[ADDR_W-1:0];
            f_top  = nsreg[ADDR_W-1:ADDR_W-2];
        end
        if (done) d.act = PG_NONE;

        if (!sel_i) begin
            d.st   = ST_IDLE;
            d.dout = 1'b0;
            if (q.pend != PG_NONE) begin
                start  = 1'b1;
                d.act  = q.pend;
                d.pend = PG_NONE;
            end
        end else if (sk_rise) begin
            unique case (q.st)
                ST_IDLE: begin
                    if (sdi_i) begin
                        if (busy) begin
                            d.st = ST_HOLD;
                        end else begin
                            d.st   = ST_CMD;
                            d.cnt  = '0;
                            d.sreg = '0;
                            d.wide = wide_i;
                        end
                    end
                end
                ST_CMD: begin
                    d.sreg = nsreg;
                    d.cnt  = q.cnt + 1'b1;
                    if (q.cnt == aw + CNT_W'(1)) begin
                        d.addr = f_addr;
                        d.cnt  = '0;
                        d.st   = ST_HOLD;
                        unique case (op)
                            OP_READ: begin
                                d.st   = ST_READ;
                                d.dout = 1'b0;
                            end
                            OP_WRITE: begin
                                d.st    = ST_DATA;
                                d.wdata = '0;
                            end
                            OP_CTRL: begin
                                if (f_top == CTL_ENABLE)       d.ewen = 1'b1;
                                else if (f_top == CTL_DISABLE) d.ewen = 1'b0;
                                else if (f_top == CTL_ERASE && q.ewen) d.pend = PG_ERASE;
                            end
                            default: ;
                        endcase
                    end
                end
                ST_DATA: begin
                    d.wdata = nwdata;
                    d.cnt   = q.cnt + 1'b1;
                    if (q.cnt == dw - 1'b1) begin
                        d.st = ST_HOLD;
                        if (q.ewen) begin
                            d.pend   = PG_WRITE;
                            d.p_addr = q.addr;
                            d.p_data = nwdata;
                            d.p_wide = q.wide;
                        end
                    end
                end
                ST_READ: begin
                    d.dout = rd_word[bidx];
                    if (q.cnt == dw - 1'b1) begin
                        d.cnt = '0;
                        if (q.wide) d.addr = {1'b0, q.addr[ADDR_W-2:0] + 1'b1};
                        else        d.addr = q.addr + 1'b1;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sdo_o = sel_i & ((q.st == ST_READ) ? q.dout : ~busy);

    // R2: the first bit seen after entering a read is the 0 dummy
    a_r2_dummy_first: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_READ && $past(q.st) != ST_READ) |-> !q.dout);

    // R7: programming only starts when the enable latch was set
    a_r7_armed_only: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(q.ewen));

    // R9: a start bit during programming never opens a command frame
    a_r9_busy_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sel_i && sk_rise && q.st == ST_IDLE) |=> q.st != ST_CMD);

endmodule

// File: tb/tw_eeprom_tb_top.sv
module tw_eeprom_tb_top;

    localparam int ADDR_W = 7;
    localparam int PROG   = 40;
    localparam int HALF   = 2;
    localparam int BYTES  = 1 << ADDR_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel = 1'b0, sclk = 1'b0, sdi = 1'b0, org = 1'b0;
    logic sdo;

    int total = 0;
    int fails = 0;
    bit finished = 1'b0;
    logic [7:0] model [BYTES];

    always #5 clk = ~clk;

    tw_eeprom #(.ADDR_W(ADDR_W), .PROG_CYCLES(PROG)) dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_i  (sel),
        .sclk_i (sclk),
        .sdi_i  (sdi),
        .wide_i (org),
        .sdo_o  (sdo)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sk_pulse();
        sclk = 1'b1; tick(HALF);
        sclk = 1'b0; tick(HALF);
    endtask

    task automatic send_bits(input logic [15:0] val, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            sdi = val[i];
            sk_pulse();
        end
        sdi = 1'b0;
    endtask

    function automatic int aw_of(input logic wide);
        return wide ? ADDR_W - 1 : ADDR_W;
    endfunction

    task automatic open_cmd(input logic wide, input logic [1:0] op, input int addr);
        org = wide;
        sel = 1'b1; tick(HALF);
        send_bits(16'h1, 1);
        send_bits(16'(op), 2);
        send_bits(16'(addr), aw_of(wide));
    endtask

    // Release select and measure the programming time (R8) or its absence (R7)
    task automatic finish_prog(input bit armed);
        int k;
        sel = 1'b0; #1;
        chk(sdo == 1'b0, "R11 sdo low while deselected", sdo, 0);
        @(negedge clk);
        sel = 1'b1; #1;
        k = 1;
        while (sdo == 1'b0 && k < 1000) begin
            @(negedge clk); #1;
            k++;
        end
        if (armed) chk(k == PROG + 1, "R8 busy length", k, PROG + 1);
        else       chk(k == 1, "R7 disabled op starts no cycle", k, 1);
        sel = 1'b0; tick(2);
    endtask

    task automatic ctrl(input logic wide, input logic [1:0] top, input bit prog, input bit armed);
        open_cmd(wide, 2'b01, int'(top) << (aw_of(wide) - 2));
        if (prog) finish_prog(armed);
        else begin sel = 1'b0; tick(2); end
    endtask

    task automatic write_val(input logic wide, input int addr, input logic [15:0] data, input bit armed);
        open_cmd(wide, 2'b10, addr);
        send_bits(data, wide ? 16 : 8);
        finish_prog(armed);
        if (armed) begin
            if (wide) begin
                model[2 * addr]     = data[15:8];
                model[2 * addr + 1] = data[7:0];
            end else begin
                model[addr] = data[7:0];
            end
        end
    endtask

    function automatic logic [15:0] exp_val(input logic wide, input int a);
        if (wide) return {model[2 * a], model[2 * a + 1]};
        return {8'h00, model[a]};
    endfunction

    task automatic read_run(input logic wide, input int start, input int n, input string tag);
        int depth, dw;
        logic [15:0] w, e;
        depth = 1 << aw_of(wide);
        dw    = wide ? 16 : 8;
        open_cmd(wide, 2'b00, start);
        chk(sdo == 1'b0, "R2 dummy bit", sdo, 0);
        for (int i = 0; i < n; i++) begin
            w = '0;
            for (int b = 0; b < dw; b++) begin
                sk_pulse();
                w = {w[14:0], sdo};
            end
            e = exp_val(wide, (start + i) % depth);
            chk(w == e, tag, w, e);
        end
        sel = 1'b0; tick(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(2);
        // Reset state
        #1 chk(sdo == 1'b0, "R11 reset deselected", sdo, 0);
        sel = 1'b1; #1;
        chk(sdo == 1'b1, "R8 ready after reset", sdo, 1);
        sel = 1'b0; tick(2);

        // R7/R5: erase-all with the latch clear after reset is ignored
        ctrl(1'b0, 2'b10, 1'b1, 1'b0);

        // R5 enable, then R6 erase-all
        ctrl(1'b0, 2'b11, 1'b0, 1'b0);
        ctrl(1'b0, 2'b10, 1'b1, 1'b1);
        for (int a = 0; a < BYTES; a++) model[a] = 8'hFF;
        read_run(1'b0, 0, BYTES, "R6 erased byte");

        // R4 byte writes over the whole array, R1/R2 full read, R3 wrap
        for (int a = 0; a < BYTES; a++) write_val(1'b0, a, 16'((a * 29 + 3) & 8'hFF), 1'b1);
        read_run(1'b0, 0, BYTES, "R2 byte read data");
        read_run(1'b0, BYTES - 8, 16, "R3 byte wrap read");

        // R5 disable, R7 ignored write keeps contents
        ctrl(1'b0, 2'b00, 1'b0, 1'b0);
        write_val(1'b0, 5, 16'h0000, 1'b0);
        read_run(1'b0, 5, 1, "R7 byte unchanged");

        // R9: a frame opened during programming is dropped
        ctrl(1'b0, 2'b11, 1'b0, 1'b0);
        open_cmd(1'b0, 2'b10, 10);
        send_bits(16'h5A, 8);
        sel = 1'b0; tick(1);
        sel = 1'b1;
        send_bits(16'h1, 1);
        #1 chk(sdo == 1'b0, "R9 busy during dropped frame", sdo, 0);
        send_bits(16'h2, 2);
        send_bits(16'd11, ADDR_W);
        send_bits(16'hA5, 8);
        sel = 1'b0; tick(2);
        model[10] = 8'h5A;
        sel = 1'b1; #1;
        chk(sdo == 1'b1, "R9 no cycle from dropped frame", sdo, 1);
        sel = 1'b0; tick(2);
        read_run(1'b0, 10, 2, "R9 bytes 10..11");

        // Word organisation: R1 frame width, R4 writes, R3 wrap, R10 layout
        for (int k = 0; k < BYTES / 2; k++) write_val(1'b1, k, 16'((k * 1237 + 77) & 16'hFFFF), 1'b1);
        read_run(1'b1, 0, BYTES / 2 + 1, "R3 word read with wrap");
        read_run(1'b1, 17, 3, "R1 word frame");
        read_run(1'b0, 2 * 9, 4, "R10 byte view of words");
        org = 1'b0;

        finished = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule